// File: doc/BRIEF.md
# Run-Time Extension Control and Instruction Gating Unit

This unit sits beside the decoder of a small 32-bit core and owns the machine register that lists which instruction-set extensions are switched on. Software may rewrite that register at any time to turn the atomic, bit-manipulation, compressed and multiply/divide extensions on or off. It may also drop from the full 32-entry register file to the reduced 16-entry embedded profile. Every other function of the unit follows from the current enable set.

For each instruction presented with its PC, the unit decides whether its length is 16 or 32 bits and whether its encoding is allowed. It raises a one-cycle illegal-instruction pulse for encodings whose extension is off. When compressed instructions are disabled it halts fetch on a PC that is not word aligned. It also checks the register indices the core reads and writes against the embedded profile. Finally, it names the register that holds the environment-call function selector. Execution, the ALU and the register file itself stay outside.

Top module: `isa_ctl_unit`

## Requirements
- R1: After reset every extension is enabled. A read of CSR address 0x301 returns 0x00001107: A at bit 0, B at bit 1, C at bit 2, I at bit 8, M at bit 12, and the embedded-profile bit 4 clear.
- R2: A write to 0x301 stores bits 0, 2, 1, 12 and 8 of the write data as the A, C, B, M and I enables. A read returns those bits in the same positions, with bit 4 set exactly when I is clear and every other bit zero.
- R3: A write to 0x301 that would clear C while PC bit 1 is set (PC mod 4 = 2) and C is currently on changes no enable. In the following cycle it raises `csr_wr_rej_o` for one cycle. A write that keeps C set is accepted at any PC.
- R4: Reads of any other CSR address return zero. Writes to any other address leave the enables unchanged.
- R5: With C off, `inst_len32_o` is 1 whatever the low two bits of the word are. With C on, it is 1 only when those bits are 11. A valid instruction at a PC with nonzero low two bits while C is off sets `fetch_halt_o` from the next cycle until reset, and `halt_pc_o` holds that PC.
- R6: With M off, OP-opcode (0x33) encodings with funct7 = 1 (any funct3) and the compressed multiply (bits 15:10 = 100111, bits 6:5 = 10, bits 1:0 = 01) are illegal. Plain OP encodings such as funct7 = 0 stay legal.
- R7: With B off, the following are illegal: OP with funct7 0x10 / funct3 2, 4, 6; funct7 0x20 / funct3 4, 6, 7; funct7 0x30 / funct3 1, 5; funct7 0x24 / funct3 1, 5; funct7 0x34 / funct3 1; funct7 0x14 / funct3 1, 2, 4. Also illegal are OP-IMM (0x13) with funct3 1 and immediate 0x600, 0x601, 0x602, 0x604 or 0x605, and with funct3 5 and immediate 0x287 or 0x698. So are the compressed extend forms (bits 15:10 = 100111, bits 6:5 = 11, bits 4:2 = 001, 010, 011, bits 1:0 = 01). OP funct7 0x20 with funct3 0 stays legal.
- R8: With A off, opcode 0x2F is illegal, and so is SYSTEM (0x73) with funct3 0, rs1 = 0, rd = 0 and immediate 0x0D or 0x1D. The plain environment call (all zero fields) stays legal.
- R9: With I off, register indices 16 to 31 are out of range. `rf_rd_zero_o` is set for them (and always for index 0), and `rf_wr_block_o` is set for an out-of-range write. A strobed out-of-range access raises `rf_err_o` in the next cycle with the index, the PC and a write flag (a read takes priority). Index 0 and any index with I on never raise it.
- R10: `ecall_idx_o` is 17 when I is on and `x17_val_i` is nonzero. It is 15 when I is on and `x17_val_i` is zero, and 15 whenever I is off.
- R11: `illegal_o` is registered. It is high for exactly the cycle after a valid instruction found illegal, is never raised for a fetch that halts, and no instruction is classified once the halt is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| csr_wr_en_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| csr_wr_rej_o | output | 1 | Pulse: write to the enable register refused |
| inst_valid_i | input | 1 | Instruction present for classification |
| inst_pc_i | input | 32 | PC of the current instruction (also used by CSR writes) |
| inst_word_i | input | 32 | Fetched instruction bits |
| inst_len32_o | output | 1 | Instruction is treated as 32 bits |
| illegal_o | output | 1 | Pulse: instruction needs a disabled extension |
| fetch_halt_o | output | 1 | Sticky misaligned-fetch halt |
| halt_pc_o | output | 32 | PC that caused the halt |
| rf_rd_en_i | input | 1 | Register read strobe |
| rf_rd_idx_i | input | 5 | Register read index |
| rf_wr_en_i | input | 1 | Register write strobe |
| rf_wr_idx_i | input | 5 | Register write index |
| rf_rd_zero_o | output | 1 | Read data must be forced to zero |
| rf_wr_block_o | output | 1 | Write must be discarded |
| rf_err_o | output | 1 | Pulse: out-of-range register access |
| rf_err_wr_o | output | 1 | Reported access was a write |
| rf_err_idx_o | output | 5 | Index of the reported access |
| rf_err_pc_o | output | 32 | PC of the reported access |
| x17_val_i | input | 32 | Current contents of register 17 |
| ecall_idx_o | output | 5 | Register holding the environment-call selector |

## Verification
The assertions assume that `inst_pc_i` is the PC of the instruction issuing a CSR write, and that strobes and indices settle before the clock edge. They also assume the core stops presenting instructions once halt is raised, although the unit tolerates further ones. The stimulus drives every input on the falling edge, holds each strobe for a single cycle, and changes the enable set only through ordinary CSR writes issued between instructions. The misaligned-fetch halt is provoked once, at the end of the run, so the sticky state does not mask earlier cases.

// File: rtl/isa_ctl_pkg.sv
package isa_ctl_pkg;

   typedef struct packed {
      logic m;
      logic i;
      logic c;
      logic b;
      logic a;
   } ext_set_t;

   localparam int POS_A = 0;
   localparam int POS_B = 1;
   localparam int POS_C = 2;
   localparam int POS_E = 4;
   localparam int POS_I = 8;
   localparam int POS_M = 12;

   localparam logic [6:0] OPC_OP    = 7'h33;
   localparam logic [6:0] OPC_OPIMM = 7'h13;
   localparam logic [6:0] OPC_AMO   = 7'h2F;
   localparam logic [6:0] OPC_SYS   = 7'h73;

   localparam ext_set_t EXT_RESET = '{m: 1'b1, i: 1'b1, c: 1'b1, b: 1'b1, a: 1'b1};

endpackage

// File: rtl/isa_csr_reg.sv
module isa_csr_reg
   import isa_ctl_pkg::*;
#(
   parameter int                XLEN     = 32,
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h301
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [XLEN-1:0]   wdata,
   input  logic              pc_odd_half,
   output logic [XLEN-1:0]   rdata,
   output ext_set_t          ext_o,
   output logic              rej_o
);

   ext_set_t ext_q;
   ext_set_t ext_new;
   logic     hit;
   logic     reject;
   logic     rej_q;
   logic     unused_wbits;

   assign hit          = (addr == CSR_ADDR);
   assign unused_wbits = ^wdata;

   always_comb begin
      ext_new.a = wdata[POS_A];
      ext_new.b = wdata[POS_B];
      ext_new.c = wdata[POS_C];
      ext_new.i = wdata[POS_I];
      ext_new.m = wdata[POS_M];
   end

   // a write may not drop compressed mode while sitting on a halfword
   assign reject = wr_en & hit & pc_odd_half & ext_q.c & ~wdata[POS_C];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= EXT_RESET;
         rej_q <= 1'b0;
      end else begin
         rej_q <= reject;
         if (wr_en && hit && !reject) ext_q <= ext_new;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[POS_A] = ext_q.a;
         rdata[POS_B] = ext_q.b;
         rdata[POS_C] = ext_q.c;
         rdata[POS_I] = ext_q.i;
         rdata[POS_M] = ext_q.m;
         rdata[POS_E] = ~ext_q.i;
      end
   end

   assign ext_o = ext_q;
   assign rej_o = rej_q;

   assert_reject_keeps_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> ext_o.c);
   assert_reject_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> rej_o);
   assert_foreign_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && hit)) |=> (ext_o == $past(ext_o)));

endmodule

// File: rtl/isa_insn_gate.sv
module isa_insn_gate
   import isa_ctl_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic            en_a,
   input  logic            en_b,
   input  logic            en_c,
   input  logic            en_m,
   input  logic [ILEN-1:0] word,
   output logic            len32,
   output logic            illegal
);

   localparam int NB_IMM = 7;
   localparam logic [11:0] B_IMM [NB_IMM] = '{12'h600, 12'h601, 12'h602, 12'h604,
                                              12'h605, 12'h287, 12'h698};
   localparam logic [2:0]  B_F3  [NB_IMM] = '{3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd5, 3'd5};

   logic [6:0]  opc;
   logic [2:0]  f3;
   logic [6:0]  f7;
   logic [11:0] imm;
   logic [4:0]  rs1;
   logic [4:0]  rd;
   logic [NB_IMM-1:0] imm_hit;
   logic need_m32, need_b32, need_a32;
   logic need_m16, need_b16;
   logic b_op;

   assign opc = word[6:0];
   assign rd  = word[11:7];
   assign f3  = word[14:12];
   assign rs1 = word[19:15];
   assign imm = word[31:20];
   assign f7  = word[31:25];

   assign len32 = ~en_c | (word[1:0] == 2'b11);

   for (genvar g = 0; g < NB_IMM; g++) begin : g_bimm
      assign imm_hit[g] = (imm == B_IMM[g]) && (f3 == B_F3[g]);
   end

   always_comb begin
      unique case (f7)
         7'h10:   b_op = (f3 == 3'd2) | (f3 == 3'd4) | (f3 == 3'd6);
         7'h20:   b_op = (f3 == 3'd4) | (f3 == 3'd6) | (f3 == 3'd7);
         7'h30:   b_op = (f3 == 3'd1) | (f3 == 3'd5);
         7'h24:   b_op = (f3 == 3'd1) | (f3 == 3'd5);
         7'h34:   b_op = (f3 == 3'd1);
         7'h14:   b_op = (f3 == 3'd1) | (f3 == 3'd2) | (f3 == 3'd4);
         default: b_op = 1'b0;
      endcase
   end

   assign need_m32 = (opc == OPC_OP) && (f7 == 7'h01);
   assign need_b32 = ((opc == OPC_OP) && b_op) || ((opc == OPC_OPIMM) && (|imm_hit));
   assign need_a32 = (opc == OPC_AMO) ||
                     ((opc == OPC_SYS) && (f3 == 3'd0) && (rs1 == 5'd0) && (rd == 5'd0) &&
                      ((imm == 12'h00D) || (imm == 12'h01D)));

   assign need_m16 = (word[1:0] == 2'b01) && (word[15:10] == 6'b100111) && (word[6:5] == 2'b10);
   assign need_b16 = (word[1:0] == 2'b01) && (word[15:10] == 6'b100111) && (word[6:5] == 2'b11) &&
                     ((word[4:2] == 3'b001) || (word[4:2] == 3'b010) || (word[4:2] == 3'b011));

   assign illegal = len32 ? ((need_m32 & ~en_m) | (need_b32 & ~en_b) | (need_a32 & ~en_a))
                          : ((need_m16 & ~en_m) | (need_b16 & ~en_b));

endmodule

// File: rtl/isa_fetch_guard.sv
module isa_fetch_guard #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic [XLEN-1:0] pc,
   input  logic            en_c,
   input  logic            illegal_comb,
   output logic            illegal_o,
   output logic            halt_o,
   output logic [XLEN-1:0] halt_pc_o
);

   logic            misalign;
   logic            halted_q;
   logic            illegal_q;
   logic [XLEN-1:0] halt_pc_q;

   assign misalign = valid & ~en_c & (pc[1:0] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q  <= 1'b0;
         illegal_q <= 1'b0;
         halt_pc_q <= '0;
      end else begin
         illegal_q <= valid & ~halted_q & ~misalign & illegal_comb;
         if (misalign && !halted_q) begin
            halted_q  <= 1'b1;
            halt_pc_q <= pc;
         end
      end
   end

   assign illegal_o = illegal_q;
   assign halt_o    = halted_q;
   assign halt_pc_o = halt_pc_q;

   assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);
   assert_halt_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (misalign && !halt_o) |=> (halt_pc_o == $past(pc)));
   assert_illegal_after_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $past(valid));
   assert_no_illegal_on_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> !illegal_o);

endmodule

// File: rtl/isa_reg_guard.sv
module isa_reg_guard #(
   parameter int XLEN   = 32,
   parameter int NREG   = 32,
   parameter int NREG_E = 16,
   parameter int SEL_I  = 17,
   parameter int SEL_E  = 15,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             e_mode,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  sel_val,
   output logic             rd_zero,
   output logic             wr_block,
   output logic             err_o,
   output logic             err_wr_o,
   output logic [IDX_W-1:0] err_idx_o,
   output logic [XLEN-1:0]  err_pc_o,
   output logic [IDX_W-1:0] ecall_idx_o
);

   localparam logic [IDX_W-1:0] LIM   = IDX_W'(NREG_E);
   localparam logic [IDX_W-1:0] IDX_I = IDX_W'(SEL_I);
   localparam logic [IDX_W-1:0] IDX_E = IDX_W'(SEL_E);

   logic             rd_out;
   logic             wr_out;
   logic             err_q;
   logic             err_wr_q;
   logic [IDX_W-1:0] err_idx_q;
   logic [XLEN-1:0]  err_pc_q;

   assign rd_out   = e_mode & (rd_idx >= LIM);
   assign wr_out   = e_mode & (wr_idx >= LIM);
   assign rd_zero  = (rd_idx == '0) | rd_out;
   assign wr_block = wr_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q     <= 1'b0;
         err_wr_q  <= 1'b0;
         err_idx_q <= '0;
         err_pc_q  <= '0;
      end else begin
         err_q <= (rd_en & rd_out) | (wr_en & wr_out);
         if (rd_en && rd_out) begin
            err_wr_q  <= 1'b0;
            err_idx_q <= rd_idx;
            err_pc_q  <= pc;
         end else if (wr_en && wr_out) begin
            err_wr_q  <= 1'b1;
            err_idx_q <= wr_idx;
            err_pc_q  <= pc;
         end
      end
   end

   assign err_o     = err_q;
   assign err_wr_o  = err_wr_q;
   assign err_idx_o = err_idx_q;
   assign err_pc_o  = err_pc_q;

   always_comb begin
      if (e_mode)              ecall_idx_o = IDX_E;
      else if (sel_val == '0)  ecall_idx_o = IDX_E;
      else                     ecall_idx_o = IDX_I;
   end

   assert_err_index_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (err_idx_o >= LIM));
   assert_no_err_full_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!e_mode) |=> !err_o);
   assert_ecall_e_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      e_mode |-> (ecall_idx_o == IDX_E));

endmodule

// File: rtl/isa_ctl_unit.sv
module isa_ctl_unit
   import isa_ctl_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 12,
   parameter int NREG   = 32,
   parameter int NREG_E = 16,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              csr_wr_en_i,
   input  logic [ADDR_W-1:0] csr_addr_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   output logic              csr_wr_rej_o,
   input  logic              inst_valid_i,
   input  logic [XLEN-1:0]   inst_pc_i,
   input  logic [XLEN-1:0]   inst_word_i,
   output logic              inst_len32_o,
   output logic              illegal_o,
   output logic              fetch_halt_o,
   output logic [XLEN-1:0]   halt_pc_o,
   input  logic              rf_rd_en_i,
   input  logic [IDX_W-1:0]  rf_rd_idx_i,
   input  logic              rf_wr_en_i,
   input  logic [IDX_W-1:0]  rf_wr_idx_i,
   output logic              rf_rd_zero_o,
   output logic              rf_wr_block_o,
   output logic              rf_err_o,
   output logic              rf_err_wr_o,
   output logic [IDX_W-1:0]  rf_err_idx_o,
   output logic [XLEN-1:0]   rf_err_pc_o,
   input  logic [XLEN-1:0]   x17_val_i,
   output logic [IDX_W-1:0]  ecall_idx_o
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("isa_ctl_unit: XLEN must be 32");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("isa_ctl_unit: ADDR_W must be 12");
   end
   if (NREG != 32 || NREG_E >= NREG || NREG_E < 1) begin : g_bad_regs
      $error("isa_ctl_unit: register counts out of range");
   end

   ext_set_t ext;
   logic     illegal_comb;

   isa_csr_reg #(.XLEN(XLEN), .ADDR_W(ADDR_W), .CSR_ADDR(12'h301)) u_csr (
      .clk        (clk_i),
      .rst_n      (rst_ni),
      .wr_en      (csr_wr_en_i),
      .addr       (csr_addr_i),
      .wdata      (csr_wdata_i),
      .pc_odd_half(inst_pc_i[1]),
      .rdata      (csr_rdata_o),
      .ext_o      (ext),
      .rej_o      (csr_wr_rej_o)
   );

   isa_insn_gate #(.ILEN(XLEN)) u_gate (
      .en_a   (ext.a),
      .en_b   (ext.b),
      .en_c   (ext.c),
      .en_m   (ext.m),
      .word   (inst_word_i),
      .len32  (inst_len32_o),
      .illegal(illegal_comb)
   );

   isa_fetch_guard #(.XLEN(XLEN)) u_fetch (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .valid       (inst_valid_i),
      .pc          (inst_pc_i),
      .en_c        (ext.c),
      .illegal_comb(illegal_comb),
      .illegal_o   (illegal_o),
      .halt_o      (fetch_halt_o),
      .halt_pc_o   (halt_pc_o)
   );

   isa_reg_guard #(.XLEN(XLEN), .NREG(NREG), .NREG_E(NREG_E), .SEL_I(17), .SEL_E(15)) u_regs (
      .clk        (clk_i),
      .rst_n      (rst_ni),
      .e_mode     (~ext.i),
      .rd_en      (rf_rd_en_i),
      .rd_idx     (rf_rd_idx_i),
      .wr_en      (rf_wr_en_i),
      .wr_idx     (rf_wr_idx_i),
      .pc         (inst_pc_i),
      .sel_val    (x17_val_i),
      .rd_zero    (rf_rd_zero_o),
      .wr_block   (rf_wr_block_o),
      .err_o      (rf_err_o),
      .err_wr_o   (rf_err_wr_o),
      .err_idx_o  (rf_err_idx_o),
      .err_pc_o   (rf_err_pc_o),
      .ecall_idx_o(ecall_idx_o)
   );

   assert_x0_never_errs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rf_wr_en_i && rf_wr_idx_i == '0 && !rf_rd_en_i) |=> !rf_err_o);

endmodule

// File: tb/isa_ctl_unit_tb.sv
module isa_ctl_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr_en = 1'b0;
   logic [11:0] csr_addr = 12'h301;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        csr_rej;
   logic        inst_valid = 1'b0;
   logic [31:0] inst_pc = '0;
   logic [31:0] inst_word = 32'h0000_0013;
   logic        len32;
   logic        illegal;
   logic        halt;
   logic [31:0] halt_pc;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic        rd_zero;
   logic        wr_block;
   logic        rf_err;
   logic        rf_err_wr;
   logic [4:0]  rf_err_idx;
   logic [31:0] rf_err_pc;
   logic [31:0] x17_val = '0;
   logic [4:0]  ecall_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   isa_ctl_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .csr_wr_en_i(csr_wr_en), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
      .csr_rdata_o(csr_rdata), .csr_wr_rej_o(csr_rej),
      .inst_valid_i(inst_valid), .inst_pc_i(inst_pc), .inst_word_i(inst_word),
      .inst_len32_o(len32), .illegal_o(illegal), .fetch_halt_o(halt), .halt_pc_o(halt_pc),
      .rf_rd_en_i(rd_en), .rf_rd_idx_i(rd_idx), .rf_wr_en_i(wr_en), .rf_wr_idx_i(wr_idx),
      .rf_rd_zero_o(rd_zero), .rf_wr_block_o(wr_block),
      .rf_err_o(rf_err), .rf_err_wr_o(rf_err_wr), .rf_err_idx_o(rf_err_idx), .rf_err_pc_o(rf_err_pc),
      .x17_val_i(x17_val), .ecall_idx_o(ecall_idx)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] pc, output logic rej);
      @(negedge clk);
      csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d; inst_pc = pc;
      @(posedge clk); #1;
      rej = csr_rej;
      @(negedge clk);
      csr_wr_en = 1'b0; csr_addr = 12'h301;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a; #1;
      d = csr_rdata;
      csr_addr = 12'h301;
   endtask

   task automatic set_ext(input logic [31:0] d);
      logic rej;
      csr_wr(12'h301, d, 32'h0, rej);
   endtask

   // one fetch: illegal pulse one cycle later, gone the cycle after
   task automatic fetch(input string req, input logic [31:0] w, input logic exp_ill);
      @(negedge clk);
      inst_valid = 1'b1; inst_word = w; inst_pc = 32'h100;
      @(posedge clk); #1;
      chk(req, $sformatf("illegal for %h", w), {31'b0, illegal}, {31'b0, exp_ill});
      @(negedge clk);
      inst_valid = 1'b0; inst_word = 32'h13;
      @(posedge clk); #1;
      chk("R11", "illegal pulse ends", {31'b0, illegal}, 32'h0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      csr_rd(12'h301, d);
      chk("R1", "reset enables", d, 32'h0000_1107);
      chk("R1", "reset halt", {31'b0, halt}, 32'h0);
      chk("R1", "reset illegal", {31'b0, illegal}, 32'h0);
   endtask

   task automatic t_csr_rw;
      logic [31:0] d;
      set_ext(32'hFFFF_FFFF);
      csr_rd(12'h301, d);
      chk("R2", "write all ones", d, 32'h0000_1107);
      set_ext(32'h0000_1006);
      csr_rd(12'h301, d);
      chk("R2", "I off gives E bit", d, 32'h0000_1016);
      set_ext(32'h0000_0000);
      csr_rd(12'h301, d);
      chk("R2", "all off", d, 32'h0000_0010);
      set_ext(32'h0000_1107);
   endtask

   task automatic t_other_addr;
      logic [31:0] d;
      logic rej;
      csr_rd(12'h300, d);
      chk("R4", "other address reads zero", d, 32'h0);
      csr_wr(12'h300, 32'h0, 32'h0, rej);
      csr_rd(12'h301, d);
      chk("R4", "other address write ignored", d, 32'h0000_1107);
   endtask

   task automatic t_reject;
      logic [31:0] d;
      logic rej;
      csr_wr(12'h301, 32'h0000_1103, 32'h102, rej);
      chk("R3", "reject pulse", {31'b0, rej}, 32'h1);
      csr_rd(12'h301, d);
      chk("R3", "rejected write no effect", d, 32'h0000_1107);
      @(posedge clk); #1;
      chk("R3", "reject pulse one cycle", {31'b0, csr_rej}, 32'h0);
      csr_wr(12'h301, 32'h0000_1106, 32'h102, rej);
      chk("R3", "keep-C write not rejected", {31'b0, rej}, 32'h0);
      csr_rd(12'h301, d);
      chk("R3", "keep-C write accepted", d, 32'h0000_1106);
      set_ext(32'h0000_1107);
   endtask

   task automatic t_m_gate;
      fetch("R6", 32'h0200_0033, 1'b0);
      set_ext(32'h0000_0107);
      fetch("R6", 32'h0200_0033, 1'b1);
      fetch("R6", 32'h0200_7033, 1'b1);
      fetch("R6", 32'h0000_9C41, 1'b1);
      fetch("R6", 32'h0000_0033, 1'b0);
      set_ext(32'h0000_1107);
      fetch("R6", 32'h0000_9C41, 1'b0);
   endtask

   task automatic t_b_gate;
      fetch("R7", 32'h4000_7033, 1'b0);
      set_ext(32'h0000_1105);
      fetch("R7", 32'h4000_7033, 1'b1);
      fetch("R7", 32'h2000_2033, 1'b1);
      fetch("R7", 32'h6000_1033, 1'b1);
      fetch("R7", 32'h6000_1013, 1'b1);
      fetch("R7", 32'h6980_5013, 1'b1);
      fetch("R7", 32'h0000_9C65, 1'b1);
      fetch("R7", 32'h4000_0033, 1'b0);
      fetch("R7", 32'h0000_1013, 1'b0);
      set_ext(32'h0000_1107);
   endtask

   task automatic t_a_gate;
      fetch("R8", 32'h0000_202F, 1'b0);
      set_ext(32'h0000_1106);
      fetch("R8", 32'h0000_202F, 1'b1);
      fetch("R8", 32'h00D0_0073, 1'b1);
      fetch("R8", 32'h01D0_0073, 1'b1);
      fetch("R8", 32'h0000_0073, 1'b0);
      set_ext(32'h0000_1107);
   endtask

   task automatic t_regs;
      set_ext(32'h0000_1007);
      @(negedge clk);
      rd_idx = 5'd20; wr_idx = 5'd15; #1;
      chk("R9", "high read forced zero", {31'b0, rd_zero}, 32'h1);
      chk("R9", "index 15 write allowed", {31'b0, wr_block}, 32'h0);
      rd_en = 1'b1; inst_pc = 32'h200;
      @(posedge clk); #1;
      chk("R9", "read error", {31'b0, rf_err}, 32'h1);
      chk("R9", "read error idx", {27'b0, rf_err_idx}, 32'd20);
      chk("R9", "read error kind", {31'b0, rf_err_wr}, 32'h0);
      chk("R9", "read error pc", rf_err_pc, 32'h200);
      @(negedge clk);
      rd_en = 1'b0; wr_idx = 5'd31; wr_en = 1'b1; inst_pc = 32'h204; #1;
      chk("R9", "high write blocked", {31'b0, wr_block}, 32'h1);
      @(posedge clk); #1;
      chk("R9", "write error", {31'b0, rf_err}, 32'h1);
      chk("R9", "write error idx", {27'b0, rf_err_idx}, 32'd31);
      chk("R9", "write error kind", {31'b0, rf_err_wr}, 32'h1);
      @(negedge clk);
      wr_idx = 5'd0; rd_idx = 5'd0; #1;
      chk("R9", "x0 reads zero", {31'b0, rd_zero}, 32'h1);
      @(posedge clk); #1;
      chk("R9", "x0 write no error", {31'b0, rf_err}, 32'h0);
      @(negedge clk);
      wr_en = 1'b0;
      set_ext(32'h0000_1107);
      @(negedge clk);
      rd_idx = 5'd20; rd_en = 1'b1; #1;
      chk("R9", "I mode high read not zeroed", {31'b0, rd_zero}, 32'h0);
      @(posedge clk); #1;
      chk("R9", "I mode no error", {31'b0, rf_err}, 32'h0);
      @(negedge clk);
      rd_en = 1'b0; rd_idx = 5'd0;
   endtask

   task automatic t_ecall;
      @(negedge clk);
      x17_val = 32'd5; #1;
      chk("R10", "I mode nonzero x17", {27'b0, ecall_idx}, 32'd17);
      x17_val = 32'd0; #1;
      chk("R10", "I mode zero x17", {27'b0, ecall_idx}, 32'd15);
      set_ext(32'h0000_1007);
      @(negedge clk);
      x17_val = 32'd5; #1;
      chk("R10", "E mode", {27'b0, ecall_idx}, 32'd15);
      set_ext(32'h0000_1107);
   endtask

   task automatic t_fetch_len;
      @(negedge clk);
      inst_word = 32'h0000_9C41; #1;
      chk("R5", "C on 16-bit length", {31'b0, len32}, 32'h0);
      set_ext(32'h0000_1103);
      @(negedge clk);
      inst_word = 32'h0000_9C41; #1;
      chk("R5", "C off always 32-bit", {31'b0, len32}, 32'h1);
      inst_valid = 1'b1; inst_pc = 32'h100; inst_word = 32'h33;
      @(posedge clk); #1;
      chk("R5", "aligned no halt", {31'b0, halt}, 32'h0);
      @(negedge clk);
      inst_pc = 32'h102; inst_word = 32'h0200_0033;
      set_ext_noop();
      @(posedge clk); #1;
      chk("R5", "misaligned halts", {31'b0, halt}, 32'h1);
      chk("R5", "halt pc", halt_pc, 32'h102);
      chk("R11", "no illegal on halt", {31'b0, illegal}, 32'h0);
      @(negedge clk);
      inst_pc = 32'h104;
      @(posedge clk); #1;
      chk("R5", "halt sticky", {31'b0, halt}, 32'h1);
      chk("R5", "halt pc kept", halt_pc, 32'h102);
      @(negedge clk);
      inst_valid = 1'b0;
   endtask

   task automatic set_ext_noop;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_csr_rw();
      t_other_addr();
      t_reject();
      t_m_gate();
      t_b_gate();
      t_a_gate();
      t_regs();
      t_ecall();
      t_fetch_len();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule